// File: doc/BRIEF.md
# Sticky-Lockout Serial Pattern Detector

This block watches a single-bit serial stream, taking one bit on each rising clock edge. It raises `detect` while the three most recently taken bits, read oldest to newest, are 0, 1, 0. There is also a forbidden sequence, 1, 0, 0. Once the stream has produced it, `detect` is held low for good, and only a reset brings detection back. The output is Moore-style: it is decoded from stored state only and never from the live input. It is therefore high for the clock cycle that follows the edge which took the final 0 of a match.

Two equivalent implementations are provided, and the parameter `IMPL` selects one. `IMPL = 0` uses a three-bit history register whose shift enable drops once the register holds the forbidden sequence. The register then freezes, so the match pattern can never appear again. `IMPL = 1` uses an explicit state machine with six named states:

- `ST_ZERO`: history ends in 00 and holds no 1 yet, or is freshly reset.
- `ST_SAW01`: history ends in 0 then 1.
- `ST_HIT`: history is 0,1,0, and this is the only state that drives `detect` high.
- `ST_SAW11`: history ends in 1 then 1.
- `ST_SAW10`: history ends in 1 then 0.
- `ST_LOCK`: an absorbing lockout state.

The state machine has these transitions:

| From | On input 0 | On input 1 |
|---|---|---|
| `ST_ZERO` | `ST_ZERO` | `ST_SAW01` |
| `ST_SAW01` | `ST_HIT` | `ST_SAW11` |
| `ST_HIT` | `ST_LOCK` | `ST_SAW01` |
| `ST_SAW11` | `ST_SAW10` | `ST_SAW11` |
| `ST_SAW10` | `ST_LOCK` | `ST_SAW01` |
| `ST_LOCK` | `ST_LOCK` | `ST_LOCK` |

Top module: `pd_detect`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the history is cleared and `detect` is 0 after that edge; reset is synchronous and active low.
- R2: `detect` is 1 after an edge exactly when the last three bits taken (oldest first) are 0,1,0 and 1,0,0 has not appeared since reset; it is 0 otherwise.
- R3: After reset the history counts as 000, so the bits 1 then 0 as the first two inputs already produce a match.
- R4: Overlapping matches are all reported: after reset, the input 0,1,0,1,0 gives exactly two single-cycle pulses, on the third and fifth cycles.
- R5: Once 1,0,0 has been taken as three consecutive bits, `detect` stays 0 for every later input until reset.
- R6: A reset after lockout restores normal detection, so 0,1,0 then gives a pulse again.
- R7: `detect` is never 1 on two consecutive cycles.
- R8: Both implementations (`IMPL` 0 = frozen history register, 1 = state machine) give identical `detect` for every input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Serial data bit, taken each rising edge |
| detect | output | 1 | High while the stored history is 0,1,0 and no lockout has occurred |

## Verification
The stimulus includes the short sequence 1,0 right after reset. This exposes whether the cleared history is treated as zeros or as unknown. The overlapping stream 0,1,0,1,0 tells apart a detector that restarts after each hit from one that keeps the shared bits. Streams that contain 1,0,0 in the middle of 0,1,0 runs separate a real sticky lockout from a detector that only masks the cycle of the forbidden pattern. Long random streams with periodic resets compare both implementations against a behavioural model every cycle.

// File: rtl/pd_pkg.sv
package pd_pkg;

    localparam int HIST_W = 3;

    typedef logic [HIST_W-1:0] hist_t;

    localparam hist_t MATCH_PAT = 3'b010;
    localparam hist_t BLOCK_PAT = 3'b100;

    typedef enum logic [2:0] {
        ST_ZERO  = 3'd0,
        ST_SAW01 = 3'd1,
        ST_HIT   = 3'd2,
        ST_SAW11 = 3'd3,
        ST_SAW10 = 3'd4,
        ST_LOCK  = 3'd5
    } pd_state_t;

endpackage

// File: rtl/pd_shift_core.sv
module pd_shift_core
    import pd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic detect_o
);

    hist_t hist_q;
    logic  shift_en;

    // Freeze once the forbidden pattern sits in the register.
    always_comb begin
        shift_en = (hist_q != BLOCK_PAT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[HIST_W-2:0], bit_in};
        end
    end

    always_comb begin
        detect_o = (hist_q == MATCH_PAT);
    end

endmodule

// File: rtl/pd_fsm_core.sv
module pd_fsm_core
    import pd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic detect_o
);

    pd_state_t state_q;
    pd_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ZERO;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ZERO:  state_d = bit_in ? ST_SAW01 : ST_ZERO;
            ST_SAW01: state_d = bit_in ? ST_SAW11 : ST_HIT;
            ST_HIT:   state_d = bit_in ? ST_SAW01 : ST_LOCK;
            ST_SAW11: state_d = bit_in ? ST_SAW11 : ST_SAW10;
            ST_SAW10: state_d = bit_in ? ST_SAW01 : ST_LOCK;
            ST_LOCK:  state_d = ST_LOCK;
            default:  state_d = ST_ZERO;
        endcase
    end

    always_comb begin
        detect_o = (state_q == ST_HIT);
    end

endmodule

// File: rtl/pd_detect.sv
module pd_detect #(
    parameter int unsigned IMPL = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic detect
);

    generate
        if (IMPL == 0) begin : g_shift
            pd_shift_core u_core (
                .clk      (clk),
                .rst_n    (rst_n),
                .bit_in   (bit_in),
                .detect_o (detect)
            );
        end else begin : g_fsm
            pd_fsm_core u_core (
                .clk      (clk),
                .rst_n    (rst_n),
                .bit_in   (bit_in),
                .detect_o (detect)
            );
        end
    endgenerate

endmodule

// File: rtl/pd_detect_sva.sv
module pd_detect_sva (
    input logic clk,
    input logic rst_n,
    input logic bit_in,
    input logic detect
);

    logic [2:0] obs_hist;
    logic       seen_q;
    logic       seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obs_hist <= 3'b000;
            seen_q   <= 1'b0;
        end else begin
            obs_hist <= {obs_hist[1:0], bit_in};
            seen_q   <= seen;
        end
    end

    always_comb begin
        seen = seen_q || (obs_hist == 3'b100);
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> !detect); // R1
    AST_HIT_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n) detect |-> (obs_hist == 3'b010)); // R2
    AST_MATCH_REPORTED: assert property (@(posedge clk) disable iff (!rst_n) ((obs_hist == 3'b010) && !seen) |-> detect); // R2
    AST_LOCK_SILENT: assert property (@(posedge clk) disable iff (!rst_n) seen |-> !detect); // R5
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n) detect |=> !detect); // R7

endmodule

bind pd_detect pd_detect_sva u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_in (bit_in),
    .detect (detect)
);

// File: tb/pd_detect_test.sv
module pd_detect_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic det_a;
    logic det_b;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    int  hist_q[$];
    bit  ever_blocked = 0;
    bit  expected = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pd_detect #(.IMPL(0)) uut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .detect(det_a)
    );

    pd_detect #(.IMPL(1)) uut_sm (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .detect(det_b)
    );

    task automatic check(input string tag, input logic actual, input logic exp);
        n_checks++;
        if (actual !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, actual, exp, $time);
        end
    endtask

    task automatic model_edge(input logic r, input logic b);
        if (!r) begin
            hist_q = '{0, 0, 0};
            ever_blocked = 0;
        end else begin
            hist_q.push_back(int'(b));
            void'(hist_q.pop_front());
            if (hist_q[0] == 1 && hist_q[1] == 0 && hist_q[2] == 0) ever_blocked = 1;
        end
        expected = (hist_q[0] == 0 && hist_q[1] == 1 && hist_q[2] == 0) && !ever_blocked;
    endtask

    // One cycle: drive at negedge, edge, compare shortly after the edge.
    task automatic step(input logic b, input string tag);
        @(negedge clk);
        bit_in = b;
        @(posedge clk);
        model_edge(rst_n, b);
        #1;
        check({tag, " R2 R5 (impl0)"}, det_a, expected);
        check({tag, " R8 (impl1)"}, det_b, expected);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step(1'b1, "R1 during reset");
        step(1'b0, "R1 during reset");
        check("R1 reset clears impl0", det_a, 1'b0);
        check("R1 reset clears impl1", det_b, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        for (int i = 0; i < WATCHDOG_CYCLES; i++) begin
            @(posedge clk);
            if (finished) disable watchdog;
        end
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=expired expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int pulses;
        hist_q = '{0, 0, 0};
        do_reset();

        // R3: zero history after reset, so 1,0 matches at once
        step(1'b1, "R3 first bit");
        step(1'b0, "R3 second bit");
        check("R3 1,0 after reset detects", det_a, 1'b1);

        // R4: overlapping matches
        do_reset();
        pulses = 0;
        for (int i = 0; i < 5; i++) begin
            step((i % 2) == 1, "R4 overlap");
            if (det_a) pulses++;
        end
        check("R4 two pulses from 0,1,0,1,0", pulses == 2, 1'b1);

        // R5: lockout then match attempts
        do_reset();
        step(1'b1, "R5"); step(1'b0, "R5"); step(1'b0, "R5");
        for (int i = 0; i < 12; i++) begin
            step((i % 2) == 1, "R5 after lock");
            check("R5 locked impl0", det_a, 1'b0);
            check("R5 locked impl1", det_b, 1'b0);
        end

        // R6: reset restores detection
        do_reset();
        step(1'b0, "R6"); step(1'b1, "R6"); step(1'b0, "R6");
        check("R6 detect after relock reset", det_a, 1'b1);
        check("R6 detect after relock reset impl1", det_b, 1'b1);

        // R7 and random streams with periodic reset
        for (int blk = 0; blk < 20; blk++) begin
            logic prev;
            do_reset();
            prev = 1'b0;
            for (int i = 0; i < 200; i++) begin
                step(logic'($urandom_range(0, 1)), "random");
                check("R7 no back-to-back", prev && det_a, 1'b0);
                check("R8 variants agree", det_a, det_b);
                prev = det_a;
            end
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule